// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. A 13-bit configuration word selects one of two divide schemes. The linear scheme gives half-periods of adjustable length in single-cycle steps. The power-of-two scheme gives half-periods that double with each step, which covers much slower bit rates. The block emits a one-cycle pulse at the end of every half-period, so a shifter can sample or launch data there. It also emits a serial clock level that toggles on each pulse.

A controller sets the configuration and the idle polarity, then raises the run input for the length of a transfer. While run is low, the block copies the configuration into its own register, holds its counter at zero and parks the clock at the requested idle polarity. While run is high, the stored configuration is frozen, so a write in the middle of a transfer cannot stretch or shorten a half-period.

Top module: `spi_sclk_divider`

## Requirements
- R1: While reset is asserted, `half_tick` is low and `sclk` is low.
- R2: At each clock edge where `run_en` is low, `sclk` takes the value of `cpol` and `half_tick` is low from that edge on.
- R3: When `div_cfg[12]` is 1 (linear scheme), a half-period lasts `div_cfg[7:0]`+1 clock cycles. The first `half_tick` comes at the (N+1)-th edge with `run_en` high, and later ones follow every N+1 edges.
- R4: When `div_cfg[12]` is 0 (power-of-two scheme), a half-period lasts 2 to the power `div_cfg[11:8]` clock cycles, with the same first-tick rule as R3.
- R5: The field that the selected scheme does not use has no effect: bits 11:8 in the linear scheme, and bits 7:0 in the power-of-two scheme.
- R6: `sclk` changes only at an edge where `half_tick` goes high. After k ticks in a run, `sclk` equals `cpol` XOR (k mod 2).
- R7: A change of `div_cfg` while `run_en` is high does not alter the half-period in use. The change takes effect after `run_en` has been low for at least one edge.
- R8: The fastest setting in either scheme (field value 0) makes `sclk` toggle at every clock edge, which is half the module clock rate.
- R9: When `run_en` falls in the middle of a half-period, `sclk` returns to `cpol` at the next edge. The next run starts a complete half-period from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | High while the serial clock should run |
| div_cfg | input | 13 | Bits 7:0 linear value, bits 11:8 exponent, bit 12 scheme select (1 = linear) |
| cpol | input | 1 | Idle level of the serial clock |
| half_tick | output | 1 | One-cycle pulse at the end of each half-period |
| sclk | output | 1 | Serial clock level |

## Verification
The bench targets the off-by-one boundaries of the half-period. A design that counted N+2 cycles or 2^N−1 cycles would misplace the first tick. The bench also covers the divide-by-two extreme, where a design that failed to reload on a hit would stall instead of toggling every cycle. Unused-field values are set to non-zero junk, so a design that decoded the wrong bit range or inverted the select would produce the wrong tick spacing. Configuration writes during a run and aborted runs are covered too: a design that latched the configuration at any time, or kept its count across a stop, would shift the tick grid.

// File: rtl/spi_sclk_pkg.sv
`timescale 1ns/1ps
package spi_sclk_pkg;

    typedef enum logic {
        DIV_POW2 = 1'b0,
        DIV_LIN  = 1'b1
    } div_mode_e;

    // Counter must reach max(linear value, 2^maxexp - 1).
    function automatic int cnt_width(input int lin_w, input int exp_w);
        int pow_bits;
        pow_bits = (1 << exp_w) - 1;
        return (lin_w > pow_bits) ? lin_w : pow_bits;
    endfunction

endpackage

// File: rtl/spi_sclk_cfg_hold.sv
`timescale 1ns/1ps
module spi_sclk_cfg_hold
    import spi_sclk_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CFG_W = LIN_W + EXP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CFG_W-1:0] cfg_word,
    output logic [LIN_W-1:0] lin_n,
    output logic [EXP_W-1:0] exp_n,
    output div_mode_e        mode
);

    typedef struct packed {
        logic [LIN_W-1:0] lin;
        logic [EXP_W-1:0] ex;
        div_mode_e        mode;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d.lin  = cfg_word[LIN_W-1:0];
            st_d.ex   = cfg_word[LIN_W+EXP_W-1:LIN_W];
            st_d.mode = div_mode_e'(cfg_word[CFG_W-1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lin: '0, ex: '0, mode: DIV_POW2};
        end else begin
            st_q <= st_d;
        end
    end

    assign lin_n = st_q.lin;
    assign exp_n = st_q.ex;
    assign mode  = st_q.mode;

endmodule

// File: rtl/spi_sclk_term_sel.sv
`timescale 1ns/1ps
module spi_sclk_term_sel
    import spi_sclk_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 15
) (
    input  logic [LIN_W-1:0] lin_n,
    input  logic [EXP_W-1:0] exp_n,
    input  div_mode_e        mode,
    output logic [CNT_W-1:0] term
);

    localparam int EXP_N = 1 << EXP_W;

    logic [CNT_W-1:0] pow_part [EXP_N];

    // One candidate terminal count per exponent value; only the matching one survives.
    for (genvar g = 0; g < EXP_N; g++) begin : g_pow
        localparam logic [CNT_W-1:0] MASK = CNT_W'((1 << g) - 1);
        assign pow_part[g] = (exp_n == EXP_W'(g)) ? MASK : '0;
    end

    logic [CNT_W-1:0] pow_term;

    always_comb begin
        pow_term = '0;
        for (int k = 0; k < EXP_N; k++) begin
            pow_term = pow_term | pow_part[k];
        end
    end

    always_comb begin
        if (mode == DIV_LIN) begin
            term = CNT_W'(lin_n);
        end else begin
            term = pow_term;
        end
    end

endmodule

// File: rtl/spi_sclk_half_cnt.sv
`timescale 1ns/1ps
module spi_sclk_half_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] term,
    output logic             hit,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } cnt_t;

    cnt_t st_d, st_q;

    assign hit = run_en && (st_q.cnt == term);

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else if (hit) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/spi_sclk_level.sv
`timescale 1ns/1ps
module spi_sclk_level (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic cpol,
    input  logic hit,
    output logic sclk
);

    typedef struct packed {
        logic lvl;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d.lvl = cpol;
        end else if (hit) begin
            st_d.lvl = ~st_q.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.lvl;

endmodule

// File: rtl/spi_sclk_divider.sv
`timescale 1ns/1ps
module spi_sclk_divider
    import spi_sclk_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CFG_W = LIN_W + EXP_W + 1,
    localparam int CNT_W = cnt_width(LIN_W, EXP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CFG_W-1:0] div_cfg,
    input  logic             cpol,
    output logic             half_tick,
    output logic             sclk
);

    logic [LIN_W-1:0] lin_n_w;
    logic [EXP_W-1:0] exp_n_w;
    div_mode_e        mode_w;
    logic [CNT_W-1:0] term_w;
    logic             hit_w;

    spi_sclk_cfg_hold #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .cfg_word (div_cfg),
        .lin_n    (lin_n_w),
        .exp_n    (exp_n_w),
        .mode     (mode_w)
    );

    spi_sclk_term_sel #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_term (
        .lin_n (lin_n_w),
        .exp_n (exp_n_w),
        .mode  (mode_w),
        .term  (term_w)
    );

    spi_sclk_half_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .term   (term_w),
        .hit    (hit_w),
        .tick   (half_tick)
    );

    spi_sclk_level u_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .cpol   (cpol),
        .hit    (hit_w),
        .sclk   (sclk)
    );

endmodule

// File: rtl/spi_sclk_divider_chk.sv
`timescale 1ns/1ps
module spi_sclk_divider_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             cpol,
    input logic             half_tick,
    input logic             sclk,
    input logic [CNT_W-1:0] term
);

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !half_tick); // R2

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (sclk == $past(cpol))); // R2

    AST_TOGGLE_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |-> (sclk != $past(sclk))); // R6

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (half_tick || $stable(sclk))); // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(term)); // R7

endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cpol      (cpol),
    .half_tick (half_tick),
    .sclk      (sclk),
    .term      (term_w)
);

// File: tb/spi_sclk_divider_test.sv
`timescale 1ns/1ps
module spi_sclk_divider_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        cpol = 1'b0;
    logic [12:0] div_cfg = '0;
    logic        half_tick;
    logic        sclk;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_sclk_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .div_cfg   (div_cfg),
        .cpol      (cpol),
        .half_tick (half_tick),
        .sclk      (sclk)
    );

    function automatic logic [12:0] lin_cfg(input int n, input int junk);
        return {1'b1, 4'(junk), 8'(n)};
    endfunction

    function automatic logic [12:0] pow_cfg(input int n, input int junk);
        return {1'b0, 4'(n), 8'(junk)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Idle with config c, then run nt half-periods of length L and compare every edge.
    task automatic run_mode(input logic [12:0] c, input logic p, input int L, input int nt,
                            input string req, input logic [12:0] mid);
        bit bad;
        int bad_act;
        int bad_exp;
        @(negedge clk);
        div_cfg = c;
        cpol    = p;
        run_en  = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        check(sclk == p && !half_tick, "R2", "idle level/tick", {half_tick, sclk}, {1'b0, p});
        @(negedge clk);
        run_en  = 1'b1;
        bad     = 1'b0;
        bad_act = 0;
        bad_exp = 0;
        for (int i = 1; i <= nt * L; i++) begin
            logic et;
            logic es;
            @(posedge clk);
            #1;
            et = (i % L) == 0;
            es = p ^ logic'((i / L) % 2);
            if (!bad && (half_tick !== et || sclk !== es)) begin
                bad     = 1'b1;
                bad_act = i * 10 + 2 * int'(half_tick) + int'(sclk);
                bad_exp = i * 10 + 2 * int'(et) + int'(es);
            end
            if (i == 1) div_cfg = mid;
        end
        check(!bad, req, "edge*10+{tick,sclk}", bad_act, bad_exp);
        @(negedge clk);
        run_en = 1'b0;
        @(posedge clk);
        #1;
        check(sclk == p && !half_tick, "R9", "level after stop", {half_tick, sclk}, {1'b0, p});
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        #1;
        check(!half_tick && !sclk, "R1", "outputs in reset", {half_tick, sclk}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_idle_pol();
        @(negedge clk);
        cpol = 1'b1;
        @(posedge clk);
        #1;
        check(sclk == 1'b1, "R2", "idle follows cpol=1", sclk, 1);
        @(negedge clk);
        cpol = 1'b0;
        @(posedge clk);
        #1;
        check(sclk == 1'b0 && !half_tick, "R2", "idle follows cpol=0", sclk, 0);
    endtask

    // Abort mid half-period; the following run must start from a full half-period (R9).
    task automatic test_abort();
        @(negedge clk);
        div_cfg = lin_cfg(2, 0);
        cpol    = 1'b0;
        @(posedge clk);
        @(negedge clk);
        run_en = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(sclk == 1'b1 && !half_tick, "R9", "level before abort", {half_tick, sclk}, 1);
        run_mode(lin_cfg(2, 0), 1'b0, 3, 4, "R9", lin_cfg(2, 0));
    endtask

    initial begin
        test_reset();
        test_idle_pol();
        run_mode(lin_cfg(0, 0),    1'b0, 1,     8, "R8", lin_cfg(0, 0));
        run_mode(lin_cfg(4, 7),    1'b1, 5,     6, "R3", lin_cfg(4, 7));      // R5 junk exponent
        run_mode(lin_cfg(255, 15), 1'b0, 256,   4, "R3", lin_cfg(255, 15));
        run_mode(pow_cfg(0, 170),  1'b1, 1,     8, "R8", pow_cfg(0, 170));    // R5 junk linear
        run_mode(pow_cfg(3, 85),   1'b0, 8,     6, "R4", pow_cfg(3, 85));     // R5
        run_mode(pow_cfg(15, 255), 1'b1, 32768, 2, "R4", pow_cfg(15, 255));
        run_mode(lin_cfg(2, 0),    1'b0, 3,     6, "R7", lin_cfg(9, 0));      // mid-run write ignored
        run_mode(lin_cfg(9, 0),    1'b0, 10,    3, "R7", lin_cfg(9, 0));      // takes effect next run
        run_mode(pow_cfg(1, 3),    1'b1, 2,     5, "R6", lin_cfg(0, 0));
        test_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule